// File: doc/BRIEF.md
# Asynchronous List Empty-Schedule Detector

This block walks a circular list of queue-head records kept in a word-addressed memory. It starts at a list base address, reads each record in full, and decides from three fields whether to move on along the record's horizontal link or to stop. The walk stops when it meets the list-head record (H marker set) on a non-interrupt queue head and no transaction has raised the reclamation flag since the last time the head was seen. A whole pass that found no work therefore ends the walk.

The block owns the reclamation flag. Starting a walk sets the flag, so the first meeting with the head never stops the walk. Transaction logic sets the flag again with `recl_set` whenever it does work. The walker clears the flag itself each time it passes the head with the flag set.

Memory reads use a valid/ready request channel and a valid/ready response channel. At most one read is in flight at any time. A request holds `req_valid` and `req_addr` steady until `req_ready` is seen high at a clock edge. A response word is taken only in a cycle where `rsp_ready` is high. The memory must hold `rsp_valid` and `rsp_data` until that cycle, and may raise `rsp_valid` only for a request it has already accepted.

Top module: `async_sched_walker`

## Requirements
- R1: In idle with `enable` high, the next edge loads `cur_addr` with `list_base` with its low 5 bits cleared, and a walk starts there.
- R2: Each record is read as 4 words at `cur_addr`+0 through `cur_addr`+3, one request at a time, in that order. The stop/continue decision is taken on the edge after the last word is accepted.
- R3: The walk stops (`stop` goes high) when the record has S-mask (word 2, bits [7:0]) equal to zero, H marker (word 1, bit 15) equal to one, and the reclamation flag low at the decision.
- R4: Otherwise the walk moves on. If the link (word 0) has bit 0 clear and bits [2:1] equal to 01 (queue head), the next record is at the link with its low 5 bits cleared. In every other case the walk resumes at the aligned list base.
- R5: A non-interrupt head with H marker one and the flag high clears the flag at the decision. Heads whose S-mask is non-zero never change the flag.
- R6: A `recl_set` pulse makes `recl` high on the next cycle. It wins over a clear in the same cycle.
- R7: Starting a walk from idle sets the reclamation flag.
- R8: `stop` stays high while `enable` is high. Dropping `enable` returns the block to idle with `stop` low, and raising it again restarts from the list base.
- R9: `req_valid` and `req_addr` are held until `req_ready` is seen. `rsp_ready` is high only while a requested word is awaited.
- R10: If `enable` falls while a record is being read, the record is completed and the block goes idle. There is no decision: `stop`, `recl` and `cur_addr` are left unchanged.
- R11: After reset `stop`, `recl`, `req_valid` and `rsp_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Walk enable; a rising start restarts from the base |
| list_base | input | 32 | List base address register value |
| recl_set | input | 1 | Pulse from transaction logic: work was done |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the read request |
| req_addr | output | 32 | Word address of the read |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Walker awaits read data |
| rsp_data | input | 32 | Read data word |
| stop | output | 1 | Walk stopped: a pass found no work |
| recl | output | 1 | Reclamation flag |
| cur_addr | output | 32 | Address of the record being visited |

## Verification
The embedded properties assume a memory that raises `rsp_valid` only while a word it accepted is still owed. They also assume that `enable` and `recl_set` change only between clock edges. The bench memory model keeps exactly one pending read, which it creates from an observed request handshake. It answers that read after a random 0 to 2 cycle delay and stalls `req_ready` at random, so the response assumption holds for every stall pattern it produces. The stimulus changes inputs just after the rising edge, and the head-clear collision is timed from the reference model's own phase.

// File: rtl/asw_pkg.sv
package asw_pkg;

  typedef enum logic [1:0] {W_IDLE, W_LAUNCH, W_FETCH, W_STOP} walk_state_e;
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fetch_state_e;

  localparam int LINK_WORD  = 0;
  localparam int CHAR_WORD  = 1;
  localparam int CAP_WORD   = 2;
  localparam int H_BIT      = 15;
  localparam int SMASK_LSB  = 0;
  localparam int SMASK_W    = 8;
  localparam int ALIGN_BITS = 5;
  localparam logic [1:0] TYP_QH = 2'b01;

  typedef struct packed {
    logic               head;
    logic [SMASK_W-1:0] smask;
  } qh_info_t;

endpackage

// File: rtl/asw_qh_fetch.sv
module asw_qh_fetch
  import asw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int QH_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              done,
  output logic [ADDR_W-1:0] link,
  output qh_info_t          info
);

  localparam int IDX_W = $clog2(QH_WORDS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(QH_WORDS - 1);

  fetch_state_e     st;
  logic [IDX_W-1:0] idx;
  logic             take;

  assign req_valid = (st == F_REQ);
  assign rsp_ready = (st == F_WAIT);
  assign req_addr  = base + ADDR_W'(idx);
  assign take      = rsp_ready && rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= F_IDLE;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= take && (idx == LAST);
      unique case (st)
        F_IDLE: if (start) begin
          idx <= '0;
          st  <= F_REQ;
        end
        F_REQ:  if (req_ready) st <= F_WAIT;
        F_WAIT: if (rsp_valid) begin
          if (idx == LAST) st <= F_IDLE;
          else begin
            idx <= idx + 1'b1;
            st  <= F_REQ;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  // field capture, one register group per decoded word
  generate
    if (ADDR_W <= DATA_W) begin : g_link
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) link <= '0;
        else if (take && idx == IDX_W'(LINK_WORD)) link <= rsp_data[ADDR_W-1:0];
      end
    end else begin : g_link_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) link <= '0;
        else if (take && idx == IDX_W'(LINK_WORD)) link <= ADDR_W'(rsp_data);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) info <= '0;
    else if (take) begin
      if (idx == IDX_W'(CHAR_WORD)) info.head  <= rsp_data[H_BIT];
      if (idx == IDX_W'(CAP_WORD))  info.smask <= rsp_data[SMASK_LSB +: SMASK_W];
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R9
  AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> st == F_WAIT); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2

endmodule

// File: rtl/asw_recl_flag.sv
module asw_recl_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic clr,
  input  logic set,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag <= 1'b0;
    else if (set || arm) flag <= 1'b1;
    else if (clr)        flag <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R6
  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> flag); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set && !arm |=> !flag); // R5

endmodule

// File: rtl/asw_walk_ctrl.sv
module asw_walk_ctrl
  import asw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] list_base,
  input  logic              done,
  input  logic [ADDR_W-1:0] link,
  input  qh_info_t          info,
  input  logic              recl,
  output logic              fetch_start,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              stop,
  output logic              arm,
  output logic              clr
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((1 << ALIGN_BITS) - 1);

  walk_state_e       st;
  logic              nonint, at_head, link_ok, decide;
  logic [ADDR_W-1:0] base_al, next_addr;

  always_comb begin
    base_al   = list_base & ~ALIGN_MASK;
    nonint    = (info.smask == '0);
    at_head   = nonint && info.head;
    link_ok   = !link[0] && (link[2:1] == TYP_QH);
    next_addr = link_ok ? (link & ~ALIGN_MASK) : base_al;
    decide    = (st == W_FETCH) && done;
  end

  assign fetch_start = (st == W_LAUNCH);
  assign stop        = (st == W_STOP);
  assign arm         = (st == W_IDLE) && enable;
  assign clr         = decide && enable && at_head && recl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= W_IDLE;
      cur_addr <= '0;
    end else begin
      unique case (st)
        W_IDLE: if (enable) begin
          cur_addr <= base_al;
          st       <= W_LAUNCH;
        end
        W_LAUNCH: st <= W_FETCH;
        W_FETCH: if (done) begin
          if (!enable)              st <= W_IDLE;
          else if (at_head && !recl) st <= W_STOP;
          else begin
            cur_addr <= next_addr;
            st       <= W_LAUNCH;
          end
        end
        W_STOP: if (!enable) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stop && enable |=> stop); // R8
  AST_STOP_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop) |-> $past(!recl)); // R3
  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> cur_addr[ALIGN_BITS-1:0] == '0); // R1
  AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !enable |=> !stop); // R8

endmodule

// File: rtl/async_sched_walker.sv
module async_sched_walker
  import asw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int QH_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] list_base,
  input  logic              recl_set,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              stop,
  output logic              recl,
  output logic [ADDR_W-1:0] cur_addr
);

  logic              fetch_start, done, arm, clr;
  logic [ADDR_W-1:0] link;
  qh_info_t          info;

  asw_qh_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .QH_WORDS(QH_WORDS)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(fetch_start), .base(cur_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .done(done), .link(link), .info(info)
  );

  asw_walk_ctrl #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .list_base(list_base),
    .done(done), .link(link), .info(info), .recl(recl),
    .fetch_start(fetch_start), .cur_addr(cur_addr), .stop(stop),
    .arm(arm), .clr(clr)
  );

  asw_recl_flag u_recl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .clr(clr), .set(recl_set), .flag(recl)
  );

  AST_NO_REQ_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !req_valid && !rsp_ready); // R3
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready)); // R2

endmodule

// File: tb/test_async_sched_walker.sv
module test_async_sched_walker;

  localparam int MI = 0, ML = 1, MR = 2, MW = 3, MD = 4, MS = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, rs = 1'b0;
  logic [31:0] base = '0;
  logic        req_valid, req_ready_d, rsp_ready, rsp_valid_d, stop, recl;
  logic [31:0] req_addr, rsp_data_d, cur_addr;

  logic [31:0] mem [0:255];
  int checks = 0, fails = 0, cyc = 0, fetches = 0;
  int m_ph = MI, m_idx = 0, dly = 0;
  logic m_recl = 1'b0, nrecl, pend = 1'b0;
  logic [31:0] m_addr = '0, pend_addr = '0;
  logic [31:0] w [0:3];

  always #4 clk = ~clk;

  async_sched_walker i_async_sched_walker (
    .clk(clk), .rst_n(rst_n), .enable(en), .list_base(base), .recl_set(rs),
    .req_valid(req_valid), .req_ready(req_ready_d), .req_addr(req_addr),
    .rsp_valid(rsp_valid_d), .rsp_ready(rsp_ready), .rsp_data(rsp_data_d),
    .stop(stop), .recl(recl), .cur_addr(cur_addr)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] next_of(input logic [31:0] lk);
    if (!lk[0] && lk[2:1] == 2'b01) return lk & ~32'h1f;
    return base & ~32'h1f;
  endfunction

  // reference model and memory, evaluated between edges
  always @(negedge clk) begin
    if (!rst_n) begin
      m_ph = MI; m_recl = 0; m_addr = 0; m_idx = 0; pend = 0;
      req_ready_d = 0; rsp_valid_d = 0; rsp_data_d = 0;
    end else begin
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
      chk(stop == (m_ph == MS), "R3 stop", 32'(stop), 32'(m_ph == MS));
      chk(recl == m_recl, "R5 recl", 32'(recl), 32'(m_recl));
      chk(cur_addr == m_addr, "R4 cur_addr", cur_addr, m_addr);
      chk(req_valid == (m_ph == MR), "R9 req_valid", 32'(req_valid), 32'(m_ph == MR));
      chk(rsp_ready == (m_ph == MW), "R9 rsp_ready", 32'(rsp_ready), 32'(m_ph == MW));
      if (m_ph == MR) chk(req_addr == m_addr + 32'(m_idx), "R2 req_addr", req_addr, m_addr + 32'(m_idx));

      rsp_valid_d = pend && dly == 0;
      rsp_data_d  = mem[pend_addr[7:0]];
      req_ready_d = ($urandom % 4) != 0;

      nrecl = m_recl;
      case (m_ph)
        MI: if (en) begin m_addr = base & ~32'h1f; nrecl = 1; m_ph = ML; end
        ML: begin m_idx = 0; m_ph = MR; end
        MR: if (req_ready_d) m_ph = MW;
        MW: if (rsp_valid_d) begin
          w[m_idx] = rsp_data_d;
          if (m_idx == 3) m_ph = MD; else begin m_idx++; m_ph = MR; end
        end
        MD: begin
          if (!en) m_ph = MI;
          else if (w[2][7:0] == 0 && w[1][15] && !m_recl) m_ph = MS;
          else begin
            if (w[2][7:0] == 0 && w[1][15]) nrecl = 0;
            m_addr = next_of(w[0]);
            m_ph = ML;
          end
        end
        MS: if (!en) m_ph = MI;
        default: m_ph = MI;
      endcase
      if (rs) nrecl = 1;
      m_recl = nrecl;

      if (rsp_valid_d && rsp_ready) pend = 0;
      else if (pend && dly > 0) dly--;
      if (req_valid && req_ready_d) begin
        pend = 1; pend_addr = req_addr; dly = $urandom % 3;
        if (req_addr[4:0] == 0) fetches++;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_stop(input int lim);
    for (int i = 0; i < lim && !stop; i++) tick(1);
  endtask

  task automatic put_qh(input int a, input logic [31:0] lk, input logic h, input logic [7:0] sm);
    mem[a]   = lk;
    mem[a+1] = 32'h5a5a_0000 | (32'(h) << 15) | 32'h0000_0123;
    mem[a+2] = 32'hc300_ab00 | 32'(sm);
    mem[a+3] = 32'hdead_beef;
  endtask

  task automatic quit_walk;
    en = 0; tick(40);
  endtask

  int f0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    // ring A: head 0x20 -> 0x40 -> 0x60 -> head; first link carries noise in bits 4:3
    put_qh(32'h20, 32'h0000_005a, 1, 8'h00);
    put_qh(32'h40, 32'h0000_0062, 0, 8'h00);
    put_qh(32'h60, 32'h0000_0022, 0, 8'h00);
    // ring B: interrupt head
    put_qh(32'h80, 32'h0000_00a2, 1, 8'h01);
    put_qh(32'ha0, 32'h0000_0082, 0, 8'h00);
    // ring C: second record ends with a terminated link
    put_qh(32'hc0, 32'h0000_00e2, 1, 8'h00);
    put_qh(32'he0, 32'h0000_0041, 0, 8'h00);
    void'($urandom(7));
    tick(3);
    rst_n = 1;
    tick(1);
    chk(!stop && !recl && !req_valid && !rsp_ready, "R11 reset state",
        {28'h0, stop, recl, req_valid, rsp_ready}, 32'h0);

    // R1, R7, R3, R5: single full pass ends the walk
    base = 32'h2c; f0 = fetches; en = 1; tick(1);
    chk(cur_addr == 32'h20, "R1 aligned start", cur_addr, 32'h20);
    tick(1);
    chk(recl == 1, "R7 arm on start", 32'(recl), 32'h1);
    wait_stop(3000);
    chk(stop == 1, "R3 stop after quiet pass", 32'(stop), 32'h1);
    chk(cur_addr == 32'h20, "R3 stopped at head", cur_addr, 32'h20);
    chk(fetches - f0 == 4, "R5 clear then stop", 32'(fetches - f0), 32'd4);
    tick(30);
    chk(stop == 1, "R8 stop held", 32'(stop), 32'h1);
    en = 0; tick(2);
    chk(stop == 0, "R8 release on disable", 32'(stop), 32'h0);
    tick(5);

    // R6: set during a pass forces another pass
    f0 = fetches; en = 1;
    for (int i = 0; i < 3000 && fetches - f0 < 2; i++) tick(1);
    rs = 1; tick(1); rs = 0;
    chk(recl == 1, "R6 set pulse", 32'(recl), 32'h1);
    wait_stop(5000);
    chk(fetches - f0 == 7, "R6 extra pass", 32'(fetches - f0), 32'd7);
    quit_walk();

    // R6: set coincides with the head clear
    f0 = fetches; en = 1;
    for (int i = 0; i < 3000 && !(m_ph == MD && m_addr == 32'h20); i++) tick(1);
    rs = 1; tick(1); rs = 0;
    chk(recl == 1, "R6 set beats clear", 32'(recl), 32'h1);
    wait_stop(5000);
    chk(fetches - f0 == 7, "R6 collision pass count", 32'(fetches - f0), 32'd7);
    quit_walk();

    // R3, R5: interrupt head never stops or clears
    base = 32'h80; en = 1; tick(400);
    chk(stop == 0, "R3 interrupt head no stop", 32'(stop), 32'h0);
    chk(recl == 1, "R5 interrupt head no clear", 32'(recl), 32'h1);
    quit_walk();

    // R4: terminated link falls back to base
    base = 32'hc0; f0 = fetches; en = 1;
    wait_stop(3000);
    chk(fetches - f0 == 3, "R4 terminated link", 32'(fetches - f0), 32'd3);
    chk(cur_addr == 32'hc0, "R4 back at base", cur_addr, 32'hc0);
    quit_walk();
    // R4: non-queue-head type also falls back
    mem[32'he0] = 32'h0000_0044;
    f0 = fetches; en = 1;
    wait_stop(3000);
    chk(fetches - f0 == 3, "R4 non-QH type", 32'(fetches - f0), 32'd3);
    quit_walk();

    // R10: disable during a record read
    base = 32'h20; en = 1;
    for (int i = 0; i < 3000 && !(m_ph == MR && m_idx == 1); i++) tick(1);
    en = 0; tick(40);
    chk(stop == 0 && !req_valid, "R10 idle after abort", {30'h0, stop, req_valid}, 32'h0);
    chk(recl == 1, "R10 flag kept", 32'(recl), 32'h1);
    chk(cur_addr == 32'h20, "R10 address kept", cur_addr, 32'h20);
    // R8: restart from base after the abort
    en = 1; wait_stop(3000);
    chk(stop == 1 && cur_addr == 32'h20, "R8 restart completes", cur_addr, 32'h20);
    quit_walk();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule